// File: doc/BRIEF.md
# Clock Fanout Output Enable Controller

This block decides, every system clock cycle, which of eight differential clock drivers and one auxiliary driver with adjustable level are switched on. It takes its inputs from two places: a group of asynchronous board pins, and fields held in a register file elsewhere on the chip. A mode pin selects which source governs the clock drivers.

In pin mode, three pins that serve as the serial control port in the other mode are read together as a 3-bit code. The code turns on a cumulative set of outputs, added in a fixed order that is not numeric. In register mode, a byte of per-output enable bits is used as it stands. A chip-enable pin and a register master enable gate everything. The auxiliary driver follows an enable pin whose polarity a register bit can invert. Its level comes from a register code in register mode and is fixed at the top level in pin mode.

Every pin passes through a two-flop synchroniser. All outputs come from registers.

Top module: `clk_fanout_enable`

## Requirements
- R1: A change on any pin reaches the outputs on the third rising clock edge after it is applied, and not earlier.
- R2: With the mode pin at 1, the code is {serClkPin, serDataPin, serLatchPin}, with serClkPin as the MSB. Code n turns on the first n+1 outputs of the order 2, 7, 4, 6, 5, 3, 8, 1. Output k (1 to 8) is chanEn bit k-1.
- R3: With the mode pin at 0, chanEn equals regChanEn bit for bit, where bit k-1 enables output k.
- R4: With chipEnPin at 0, chanEn, auxEn and auxLevelSel are all zero in both modes.
- R5: With the mode pin at 0 and regMasterEn at 0, chanEn, auxEn and auxLevelSel are all zero.
- R6: With the mode pin at 1, regMasterEn has no effect on any output.
- R7: The auxiliary request is auxEnPin XOR regAuxPolInv. When the request is 0, auxEn is 0.
- R8: In register mode, regAuxLevel maps to auxLevelSel as follows: 0 gives auxEn 0 (off), 1 gives bit 0 (-9 dBm), 2 gives bit 1 (-6 dBm), 3 gives bit 2 (-3 dBm), 4 gives bit 3 (0 dBm), and 5 to 7 give bit 4 (+3 dBm).
- R9: In pin mode, an enabled auxiliary driver always selects bit 4 (+3 dBm), whatever regAuxLevel holds.
- R10: Whenever auxEn is 0, auxLevelSel is all zeros. Whenever auxEn is 1, exactly one bit of auxLevelSel is set.
- R11: While rst_n is low, all outputs are zero.
- R12: A change on a register field input reaches the outputs on the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| modeSelPin | input | 1 | Mode pin (asynchronous): 1 selects pin mode, 0 selects register mode |
| serClkPin | input | 1 | Serial clock pin; MSB of the code in pin mode |
| serDataPin | input | 1 | Serial data pin; middle bit of the code in pin mode |
| serLatchPin | input | 1 | Serial latch pin; LSB of the code in pin mode |
| chipEnPin | input | 1 | Hardware chip enable pin, active high |
| auxEnPin | input | 1 | Auxiliary driver enable pin |
| regMasterEn | input | 1 | Register master enable (register mode only) |
| regChanEn | input | 8 | Register per-output enables; bit k-1 is output k |
| regAuxPolInv | input | 1 | Inverts the sense of auxEnPin |
| regAuxLevel | input | 3 | Auxiliary level code |
| chanEn | output | 8 | Registered clock driver enables; bit k-1 is output k |
| auxEn | output | 1 | Registered auxiliary driver enable |
| auxLevelSel | output | 5 | One-hot auxiliary level select, bit 0 is lowest |

## Verification
Two functions can act in the same cycle: the mode switch, and the gating by the chip-enable pin and the master enable. When the mode pin flips, a register-mode master enable of 0 must stop gating, and the level selection must move to the top bit, both on the same edge. The randomized stimulus changes the mode, the enables, the code and the level fields together in a single step. After the pipeline settles, every output is compared with a bench model that combines all of these inputs at once. Directed steps also check the latency of pins and of register fields separately, edge by edge.

// File: rtl/fanout_en_pkg.sv
package fanout_en_pkg;

  localparam int NUM_CHAN   = 8;
  localparam int CODE_W     = 3;
  localparam int LEVEL_W    = 3;
  localparam int NUM_LEVELS = 5;
  localparam int SYNC_DEPTH = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic parMode;  // pin mode selected
    logic gateOn;   // master gating passes
    logic auxReq;   // auxiliary request after polarity
  } ctlStrobe_t;

  // position of a zero-based channel in the pin-mode turn-on order
  function automatic int unsigned chanRank(input int unsigned ch);
    case (ch)
      1:       chanRank = 0;
      6:       chanRank = 1;
      3:       chanRank = 2;
      5:       chanRank = 3;
      4:       chanRank = 4;
      2:       chanRank = 5;
      7:       chanRank = 6;
      default: chanRank = 7;
    endcase
  endfunction

  // level index for a nonzero register code, saturating at the top level
  function automatic int unsigned levelIndex(input logic [LEVEL_W-1:0] code);
    if (int'(code) >= NUM_LEVELS) levelIndex = NUM_LEVELS - 1;
    else if (code == '0)         levelIndex = 0;
    else                         levelIndex = int'(code) - 1;
  endfunction

endpackage

// File: rtl/fanout_pin_sync.sv
module fanout_pin_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] pinOut
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[s] <= '0;
        else        stage[s] <= stage[s-1];
      end
    end
  end

  assign pinOut = stage[STAGES-1];

endmodule

// File: rtl/fanout_enable_ctrl.sv
module fanout_enable_ctrl
  import fanout_en_pkg::*;
(
  input  logic       modeSync,
  input  logic       chipEnSync,
  input  logic       auxPinSync,
  input  logic       regMasterEn,
  input  logic       regAuxPolInv,
  output ctlStrobe_t strobe
);

  always_comb begin
    strobe.parMode = modeSync;
    // in pin mode only the chip-enable pin gates
    strobe.gateOn  = chipEnSync & (modeSync | regMasterEn);
    strobe.auxReq  = auxPinSync ^ regAuxPolInv;
  end

endmodule

// File: rtl/fanout_enable_dp.sv
module fanout_enable_dp
  import fanout_en_pkg::*;
#(
  parameter int NCH  = NUM_CHAN,
  parameter int CW   = CODE_W,
  parameter int LW   = LEVEL_W,
  parameter int NLV  = NUM_LEVELS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ctlStrobe_t     strobe,
  input  logic [CW-1:0]  codeSync,
  input  logic [NCH-1:0] regChanEn,
  input  logic [LW-1:0]  regAuxLevel,
  output logic [NCH-1:0] chanEn,
  output logic           auxEn,
  output logic [NLV-1:0] auxLevelSel
);

  localparam int TOP_LEVEL = NLV - 1;

  logic [NCH-1:0] parSet;
  logic [NCH-1:0] chanNext;
  logic           auxNext;
  logic [NLV-1:0] selNext;
  int unsigned    levelIdx;

  // cumulative pin-mode set: a channel is on once the code reaches its rank
  for (genvar c = 0; c < NCH; c++) begin : g_par
    assign parSet[c] = (int'(codeSync) >= int'(chanRank(c)));
  end

  always_comb begin
    if (!strobe.gateOn)      chanNext = '0;
    else if (strobe.parMode) chanNext = parSet;
    else                     chanNext = regChanEn;
  end

  always_comb begin
    auxNext  = strobe.gateOn & strobe.auxReq &
               (strobe.parMode | (regAuxLevel != '0));
    levelIdx = strobe.parMode ? TOP_LEVEL : levelIndex(regAuxLevel);
    selNext  = '0;
    if (auxNext) selNext[levelIdx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chanEn      <= '0;
      auxEn       <= 1'b0;
      auxLevelSel <= '0;
    end else begin
      chanEn      <= chanNext;
      auxEn       <= auxNext;
      auxLevelSel <= selNext;
    end
  end

endmodule

// File: rtl/clk_fanout_enable.sv
module clk_fanout_enable
  import fanout_en_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  modeSelPin,
  input  logic                  serClkPin,
  input  logic                  serDataPin,
  input  logic                  serLatchPin,
  input  logic                  chipEnPin,
  input  logic                  auxEnPin,
  input  logic                  regMasterEn,
  input  logic [NUM_CHAN-1:0]   regChanEn,
  input  logic                  regAuxPolInv,
  input  logic [LEVEL_W-1:0]    regAuxLevel,
  output logic [NUM_CHAN-1:0]   chanEn,
  output logic                  auxEn,
  output logic [NUM_LEVELS-1:0] auxLevelSel
);

  localparam int PIN_W = CODE_W + 3;

  logic [PIN_W-1:0] pinSync;
  ctlStrobe_t       ctlStrobe;

  fanout_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_DEPTH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pinIn  ({modeSelPin, chipEnPin, auxEnPin, serClkPin, serDataPin, serLatchPin}),
    .pinOut (pinSync)
  );

  fanout_enable_ctrl u_ctrl (
    .modeSync     (pinSync[PIN_W-1]),
    .chipEnSync   (pinSync[PIN_W-2]),
    .auxPinSync   (pinSync[PIN_W-3]),
    .regMasterEn  (regMasterEn),
    .regAuxPolInv (regAuxPolInv),
    .strobe       (ctlStrobe)
  );

  fanout_enable_dp u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (ctlStrobe),
    .codeSync    (pinSync[CODE_W-1:0]),
    .regChanEn   (regChanEn),
    .regAuxLevel (regAuxLevel),
    .chanEn      (chanEn),
    .auxEn       (auxEn),
    .auxLevelSel (auxLevelSel)
  );

endmodule

// File: rtl/clk_fanout_enable_chk.sv
module clk_fanout_enable_chk
  import fanout_en_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input ctlStrobe_t            ctlStrobe,
  input logic [NUM_CHAN-1:0]   chanEn,
  input logic                  auxEn,
  input logic [NUM_LEVELS-1:0] auxLevelSel
);

  // R4 and R5: closed gate clears every output on the next edge
  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctlStrobe.gateOn) |-> (chanEn == '0 && !auxEn && auxLevelSel == '0));

  // R2: output 2 is always on in pin mode once gated
  p_par_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctlStrobe.parMode && ctlStrobe.gateOn) |-> chanEn[1]);

  // R7: no request, no auxiliary driver
  p_aux_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctlStrobe.auxReq) |-> !auxEn);

  // R9: pin mode runs the auxiliary driver at the top level
  p_par_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctlStrobe.parMode) && auxEn) |-> auxLevelSel[NUM_LEVELS-1]);

  // R10: level select zero when off, one-hot when on
  p_sel_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !auxEn |-> (auxLevelSel == '0));

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    auxEn |-> ($countones(auxLevelSel) == 1));

endmodule

bind clk_fanout_enable clk_fanout_enable_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctlStrobe   (ctlStrobe),
  .chanEn      (chanEn),
  .auxEn       (auxEn),
  .auxLevelSel (auxLevelSel)
);

// File: tb/clk_fanout_enable_bench.sv
`timescale 1ns/1ps
module clk_fanout_enable_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       modeSelPin = 1'b0, serClkPin = 1'b0, serDataPin = 1'b0, serLatchPin = 1'b0;
  logic       chipEnPin = 1'b0, auxEnPin = 1'b0;
  logic       regMasterEn = 1'b0, regAuxPolInv = 1'b0;
  logic [7:0] regChanEn = 8'h00;
  logic [2:0] regAuxLevel = 3'd0;
  logic [7:0] chanEn;
  logic       auxEn;
  logic [4:0] auxLevelSel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clk_fanout_enable u_clk_fanout_enable (
    .clk(clk), .rst_n(rst_n), .modeSelPin(modeSelPin), .serClkPin(serClkPin),
    .serDataPin(serDataPin), .serLatchPin(serLatchPin), .chipEnPin(chipEnPin),
    .auxEnPin(auxEnPin), .regMasterEn(regMasterEn), .regChanEn(regChanEn),
    .regAuxPolInv(regAuxPolInv), .regAuxLevel(regAuxLevel), .chanEn(chanEn),
    .auxEn(auxEn), .auxLevelSel(auxLevelSel)
  );

  // ---- reference model from the requirements ----
  function automatic logic [7:0] expChan();
    logic [7:0] v;
    int order [8] = '{1, 6, 3, 5, 4, 2, 7, 0};
    v = 8'h00;
    if (chipEnPin && (modeSelPin || regMasterEn)) begin
      if (modeSelPin) begin
        for (int k = 0; k <= int'({serClkPin, serDataPin, serLatchPin}); k++) v[order[k]] = 1'b1;
      end else v = regChanEn;
    end
    return v;
  endfunction

  function automatic logic expAux();
    return chipEnPin && (modeSelPin || regMasterEn) && (auxEnPin ^ regAuxPolInv)
           && (modeSelPin || regAuxLevel != 3'd0);
  endfunction

  function automatic logic [4:0] expSel();
    int idx;
    if (!expAux()) return 5'b0;
    if (modeSelPin || regAuxLevel >= 3'd5) idx = 4;
    else idx = int'(regAuxLevel) - 1;
    return 5'b1 << idx;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tagC, input string tagA);
    chk(tagC, int'(chanEn), int'(expChan()));
    chk(tagA, int'(auxEn), int'(expAux()));
    chk(tagA, int'(auxLevelSel), int'(expSel()));
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setCode(input int c);
    {serClkPin, serDataPin, serLatchPin} = c[2:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    // R11: reset holds outputs low even with everything requested
    modeSelPin = 1'b1; chipEnPin = 1'b1; auxEnPin = 1'b1; setCode(7);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R11 chan", int'(chanEn), 0);
    chk("R11 aux", int'(auxEn), 0);
    chk("R11 sel", int'(auxLevelSel), 0);
    rst_n = 1'b1;

    // R3, R7, R8: register mode
    modeSelPin = 1'b0; regMasterEn = 1'b1; regChanEn = 8'hA5; regAuxLevel = 3'd3;
    settle();
    checkAll("R3", "R8");
    chk("R8 level3", int'(auxLevelSel), 5'b00100);

    // R12: register field in one edge
    regChanEn = 8'h3C;
    @(posedge clk); @(negedge clk);
    chk("R12 chan", int'(chanEn), 8'h3C);

    // R1: pin latency, three edges
    chipEnPin = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R1 before", int'(chanEn), 8'h3C);
    @(posedge clk); @(negedge clk);
    chk("R1 after", int'(chanEn), 0);
    chk("R4 aux", int'(auxEn), 0);
    chipEnPin = 1'b1;

    // R2: every code in pin mode
    modeSelPin = 1'b1;
    for (int c = 0; c < 8; c++) begin
      setCode(c);
      settle();
      checkAll("R2", "R9");
      chk("R2 count", $countones(chanEn), c + 1);
    end
    setCode(0); settle();
    chk("R2 code0", int'(chanEn), 8'h02);

    // R6: master enable ignored in pin mode
    regMasterEn = 1'b0; setCode(3); settle();
    chk("R6 chan", int'(chanEn), 8'h6A);
    chk("R6 aux", int'(auxEn), 1);

    // R9: level register ignored in pin mode
    regAuxLevel = 3'd1; settle();
    chk("R9 sel", int'(auxLevelSel), 5'b10000);

    // R7: polarity swap
    regAuxPolInv = 1'b1; settle();
    chk("R7 inv on pin1", int'(auxEn), 0);
    chk("R10 sel off", int'(auxLevelSel), 0);
    auxEnPin = 1'b0; settle();
    chk("R7 inv on pin0", int'(auxEn), 1);
    regAuxPolInv = 1'b0; auxEnPin = 1'b1;

    // R8, R10: all level codes in register mode
    modeSelPin = 1'b0; regMasterEn = 1'b1;
    for (int l = 0; l < 8; l++) begin
      regAuxLevel = 3'(l);
      settle();
      checkAll("R3", (l == 0) ? "R10" : "R8");
    end

    // R5: master off in register mode
    regMasterEn = 1'b0; regChanEn = 8'hFF; settle();
    checkAll("R5", "R5");
    chk("R5 chan", int'(chanEn), 0);

    // R4: chip enable off in pin mode
    modeSelPin = 1'b1; chipEnPin = 1'b0; settle();
    checkAll("R4", "R4");

    // mixed random steps, mode switch and gating together
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      modeSelPin  = r[0]; chipEnPin = r[1] | r[2]; auxEnPin = r[3];
      regMasterEn = r[4] | r[5]; regAuxPolInv = r[6];
      setCode(int'(r[9:7])); regChanEn = r[17:10]; regAuxLevel = r[20:18];
      settle();
      if (!chipEnPin)                      checkAll("R4", "R4");
      else if (!modeSelPin && !regMasterEn) checkAll("R5", "R5");
      else if (modeSelPin)                 checkAll("R2", "R9");
      else                                 checkAll("R3", "R8");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule